// File: doc/BRIEF.md
# Security Violation Interrupt Aggregator

This block gathers level-sensitive violation flags from three families of protection hardware: memory protection controllers (internal and expansion), peripheral protection controllers (two internal, up to four on the expansion peripheral bus and up to four on the expansion system bus), and master security controllers. It packs these flags into 32-bit status words at fixed, sparse bit positions. It keeps software-written enable words and sends each source its own enable bit. It also drives one combined interrupt for the master security controllers.

Software reaches the block through a small word-addressed register port. A write takes effect on the clock edge where `reg_we` is high. Reads are combinational from `reg_addr`. Clearing a violation is the job of the source, not of this block. A clear write sends a one-cycle pulse out to the sources, and the status words keep following the input levels. Controller counts are parameters, with these limits: two internal peripheral controllers at most, four per peripheral expansion group, and sixteen per memory or master controller group.

Top module: `sec_irq_agg`

## Requirements
- R1: Word address 0 reads the memory controller status. Internal controller n appears at bit n and expansion controller n at bit n+16. Each bit equals its input level as sampled at the previous clock edge.
- R2: Word address 1 reads the peripheral controller status. Internal controllers occupy bits 0–1, expansion peripheral-bus controllers bits 4–7 and expansion system-bus controllers bits 20–23. Each bit shows its input level one cycle later.
- R3: Word address 3 holds the peripheral enable word, which keeps only the bits in mask 0x00F000F3. Each peripheral controller's enable output equals its bit at the position given in R2, and that output changes only after a write to address 3.
- R4: A write to word address 2 drives every peripheral controller's clear output, for exactly the next cycle, to that controller's status bit as it stood at the write edge. The written data has no effect, and reading address 2 returns 0.
- R5: Word address 4 reads the master controller status, with controller n at bit n+16. Each bit follows its input one cycle later.
- R6: Word address 6 holds the master controller enable word, which keeps only bits 16 to 16+N_MSC-1. The combined interrupt is high in any cycle where the master status word ANDed with this enable word is nonzero.
- R7: A write to word address 5 drives master clear output n, for exactly the next cycle, from bit n+16 of the written data. Reading address 5 returns 0.
- R8: Word address 7 holds the master non-secure word, masked like R6. Non-secure output n equals stored bit n+16 and changes only after a write to address 7.
- R9: Writes to addresses 0, 1 and 4 leave the status words unchanged.
- R10: Reset clears all enable, non-secure and clear state, so every output and every stored word reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mpc_int_i | input | N_MPC | Internal memory controller violation levels |
| mpcx_int_i | input | N_MPCX | Expansion memory controller violation levels |
| ppc_core_int_i | input | N_PC | Internal peripheral controller violation levels |
| ppc_pexp_int_i | input | N_PP | Expansion peripheral-bus controller violation levels |
| ppc_sexp_int_i | input | N_PS | Expansion system-bus controller violation levels |
| msc_int_i | input | N_MSC | Master security controller violation levels |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| ppc_core_en_o | output | N_PC | Interrupt enables to internal peripheral controllers |
| ppc_pexp_en_o | output | N_PP | Interrupt enables to expansion peripheral-bus controllers |
| ppc_sexp_en_o | output | N_PS | Interrupt enables to expansion system-bus controllers |
| ppc_core_clr_o | output | N_PC | Clear pulses to internal peripheral controllers |
| ppc_pexp_clr_o | output | N_PP | Clear pulses to expansion peripheral-bus controllers |
| ppc_sexp_clr_o | output | N_PS | Clear pulses to expansion system-bus controllers |
| msc_clr_o | output | N_MSC | Clear pulses to master controllers |
| msc_ns_o | output | N_MSC | Non-secure settings to master controllers |
| msc_irq_o | output | 1 | Combined master controller interrupt |

## Verification
Some behaviours are checked by the assertions on every cycle: one-cycle tracking of each status group, clear outputs that stay silent unless the matching clear address was written, the values carried by each clear pulse, enables and non-secure outputs that hold between writes, and the combined interrupt matching status AND enable. Other behaviours only the bench scenarios can show. These are the exact sparse bit placement seen through reads, the masking of enable and non-secure writes, read-as-zero clear addresses, status words that ignore writes, and the reset values. The bench sweeps every memory and peripheral input pattern and every master status and enable pairing of the small default configuration.

// File: rtl/sia_pkg.sv
package sia_pkg;
  localparam int WORD_W        = 32;
  localparam int ADDR_W        = 3;
  localparam int EXP_BASE      = 16;
  localparam int PPC_CORE_BASE = 0;
  localparam int PPC_PEXP_BASE = 4;
  localparam int PPC_SEXP_BASE = 20;

  typedef enum logic [ADDR_W-1:0] {
    RA_MPC_STAT = 3'd0,
    RA_PPC_STAT = 3'd1,
    RA_PPC_CLR  = 3'd2,
    RA_PPC_EN   = 3'd3,
    RA_MSC_STAT = 3'd4,
    RA_MSC_CLR  = 3'd5,
    RA_MSC_EN   = 3'd6,
    RA_MSC_NS   = 3'd7
  } reg_addr_e;

  // Ones in bit positions base .. base+n-1
  function automatic logic [WORD_W-1:0] field_mask(int base, int n);
    logic [WORD_W-1:0] m;
    m = '0;
    for (int i = 0; i < WORD_W; i++) begin
      if (i >= base && i < base + n) m[i] = 1'b1;
    end
    return m;
  endfunction

  function automatic logic [WORD_W-1:0] ppc_mask(int n_core, int n_pexp, int n_sexp);
    return field_mask(PPC_CORE_BASE, n_core) |
           field_mask(PPC_PEXP_BASE, n_pexp) |
           field_mask(PPC_SEXP_BASE, n_sexp);
  endfunction

  function automatic logic [WORD_W-1:0] msc_mask(int n_msc);
    return field_mask(EXP_BASE, n_msc);
  endfunction
endpackage

// File: rtl/sia_status_pack.sv
module sia_status_pack
  import sia_pkg::*;
#(
  parameter int N_MPC  = 4,
  parameter int N_MPCX = 4,
  parameter int N_PC   = 2,
  parameter int N_PP   = 4,
  parameter int N_PS   = 4,
  parameter int N_MSC  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_MPC-1:0]  mpc_i,
  input  logic [N_MPCX-1:0] mpcx_i,
  input  logic [N_PC-1:0]   pc_i,
  input  logic [N_PP-1:0]   pp_i,
  input  logic [N_PS-1:0]   ps_i,
  input  logic [N_MSC-1:0]  msc_i,
  output logic [WORD_W-1:0] mpc_word_o,
  output logic [WORD_W-1:0] ppc_word_o,
  output logic [WORD_W-1:0] msc_word_o
);
  logic [WORD_W-1:0] mpc_d, ppc_d, msc_d;

  always_comb begin
    mpc_d = '0;
    ppc_d = '0;
    msc_d = '0;
    mpc_d[0 +: N_MPC]               = mpc_i;
    mpc_d[EXP_BASE +: N_MPCX]       = mpcx_i;
    ppc_d[PPC_CORE_BASE +: N_PC]    = pc_i;
    ppc_d[PPC_PEXP_BASE +: N_PP]    = pp_i;
    ppc_d[PPC_SEXP_BASE +: N_PS]    = ps_i;
    msc_d[EXP_BASE +: N_MSC]        = msc_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mpc_word_o <= '0;
      ppc_word_o <= '0;
      msc_word_o <= '0;
    end else begin
      mpc_word_o <= mpc_d;
      ppc_word_o <= ppc_d;
      msc_word_o <= msc_d;
    end
  end
endmodule

// File: rtl/sia_ctrl_regs.sv
module sia_ctrl_regs
  import sia_pkg::*;
#(
  parameter int N_PC  = 2,
  parameter int N_PP  = 4,
  parameter int N_PS  = 4,
  parameter int N_MSC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [WORD_W-1:0] ppc_stat_i,
  output logic [WORD_W-1:0] ppc_en_o,
  output logic [WORD_W-1:0] msc_en_o,
  output logic [WORD_W-1:0] msc_ns_o,
  output logic [WORD_W-1:0] ppc_clr_o,
  output logic [WORD_W-1:0] msc_clr_o
);
  localparam logic [WORD_W-1:0] PPC_MASK = ppc_mask(N_PC, N_PP, N_PS);
  localparam logic [WORD_W-1:0] MSC_MASK = msc_mask(N_MSC);

  logic wr_ppc_en, wr_ppc_clr, wr_msc_en, wr_msc_clr, wr_msc_ns;

  assign wr_ppc_en  = we_i && (addr_i == RA_PPC_EN);
  assign wr_ppc_clr = we_i && (addr_i == RA_PPC_CLR);
  assign wr_msc_en  = we_i && (addr_i == RA_MSC_EN);
  assign wr_msc_clr = we_i && (addr_i == RA_MSC_CLR);
  assign wr_msc_ns  = we_i && (addr_i == RA_MSC_NS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ppc_en_o  <= '0;
      msc_en_o  <= '0;
      msc_ns_o  <= '0;
      ppc_clr_o <= '0;
      msc_clr_o <= '0;
    end else begin
      if (wr_ppc_en) ppc_en_o <= wdata_i & PPC_MASK;
      if (wr_msc_en) msc_en_o <= wdata_i & MSC_MASK;
      if (wr_msc_ns) msc_ns_o <= wdata_i & MSC_MASK;
      ppc_clr_o <= wr_ppc_clr ? (ppc_stat_i & PPC_MASK) : '0;
      msc_clr_o <= wr_msc_clr ? (wdata_i & MSC_MASK) : '0;
    end
  end
endmodule

// File: rtl/sia_read_mux.sv
module sia_read_mux
  import sia_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] mpc_word_i,
  input  logic [WORD_W-1:0] ppc_word_i,
  input  logic [WORD_W-1:0] msc_word_i,
  input  logic [WORD_W-1:0] ppc_en_i,
  input  logic [WORD_W-1:0] msc_en_i,
  input  logic [WORD_W-1:0] msc_ns_i,
  output logic [WORD_W-1:0] rdata_o
);
  always_comb begin
    unique case (reg_addr_e'(addr_i))
      RA_MPC_STAT: rdata_o = mpc_word_i;
      RA_PPC_STAT: rdata_o = ppc_word_i;
      RA_PPC_EN:   rdata_o = ppc_en_i;
      RA_MSC_STAT: rdata_o = msc_word_i;
      RA_MSC_EN:   rdata_o = msc_en_i;
      RA_MSC_NS:   rdata_o = msc_ns_i;
      default:     rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/sec_irq_agg.sv
module sec_irq_agg
  import sia_pkg::*;
#(
  parameter int N_MPC  = 4,
  parameter int N_MPCX = 4,
  parameter int N_PC   = 2,
  parameter int N_PP   = 4,
  parameter int N_PS   = 4,
  parameter int N_MSC  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_MPC-1:0]  mpc_int_i,
  input  logic [N_MPCX-1:0] mpcx_int_i,
  input  logic [N_PC-1:0]   ppc_core_int_i,
  input  logic [N_PP-1:0]   ppc_pexp_int_i,
  input  logic [N_PS-1:0]   ppc_sexp_int_i,
  input  logic [N_MSC-1:0]  msc_int_i,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic [N_PC-1:0]   ppc_core_en_o,
  output logic [N_PP-1:0]   ppc_pexp_en_o,
  output logic [N_PS-1:0]   ppc_sexp_en_o,
  output logic [N_PC-1:0]   ppc_core_clr_o,
  output logic [N_PP-1:0]   ppc_pexp_clr_o,
  output logic [N_PS-1:0]   ppc_sexp_clr_o,
  output logic [N_MSC-1:0]  msc_clr_o,
  output logic [N_MSC-1:0]  msc_ns_o,
  output logic              msc_irq_o
);
  // Named internal words, observed by the bound checker
  logic [WORD_W-1:0] mpc_word_w, ppc_word_w, msc_word_w;
  logic [WORD_W-1:0] ppc_en_w, msc_en_w, msc_ns_w, ppc_clr_w, msc_clr_w;
  logic [WORD_W-1:0] msc_pending_w;

  sia_status_pack #(
    .N_MPC(N_MPC), .N_MPCX(N_MPCX), .N_PC(N_PC),
    .N_PP(N_PP), .N_PS(N_PS), .N_MSC(N_MSC)
  ) pack_i (
    .clk(clk), .rst_n(rst_n),
    .mpc_i(mpc_int_i), .mpcx_i(mpcx_int_i),
    .pc_i(ppc_core_int_i), .pp_i(ppc_pexp_int_i), .ps_i(ppc_sexp_int_i),
    .msc_i(msc_int_i),
    .mpc_word_o(mpc_word_w), .ppc_word_o(ppc_word_w), .msc_word_o(msc_word_w)
  );

  sia_ctrl_regs #(
    .N_PC(N_PC), .N_PP(N_PP), .N_PS(N_PS), .N_MSC(N_MSC)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .we_i(reg_we), .addr_i(reg_addr), .wdata_i(reg_wdata),
    .ppc_stat_i(ppc_word_w),
    .ppc_en_o(ppc_en_w), .msc_en_o(msc_en_w), .msc_ns_o(msc_ns_w),
    .ppc_clr_o(ppc_clr_w), .msc_clr_o(msc_clr_w)
  );

  sia_read_mux rmux_i (
    .addr_i(reg_addr),
    .mpc_word_i(mpc_word_w), .ppc_word_i(ppc_word_w), .msc_word_i(msc_word_w),
    .ppc_en_i(ppc_en_w), .msc_en_i(msc_en_w), .msc_ns_i(msc_ns_w),
    .rdata_o(reg_rdata)
  );

  // Fan the packed words back out to per-source pins
  assign ppc_core_en_o  = ppc_en_w[PPC_CORE_BASE +: N_PC];
  assign ppc_pexp_en_o  = ppc_en_w[PPC_PEXP_BASE +: N_PP];
  assign ppc_sexp_en_o  = ppc_en_w[PPC_SEXP_BASE +: N_PS];
  assign ppc_core_clr_o = ppc_clr_w[PPC_CORE_BASE +: N_PC];
  assign ppc_pexp_clr_o = ppc_clr_w[PPC_PEXP_BASE +: N_PP];
  assign ppc_sexp_clr_o = ppc_clr_w[PPC_SEXP_BASE +: N_PS];
  assign msc_clr_o      = msc_clr_w[EXP_BASE +: N_MSC];
  assign msc_ns_o       = msc_ns_w[EXP_BASE +: N_MSC];

  assign msc_pending_w  = msc_word_w & msc_en_w;
  assign msc_irq_o      = |msc_pending_w;
endmodule

// File: rtl/sia_checker.sv
module sia_checker #(
  parameter int N_MPC  = 4,
  parameter int N_MPCX = 4,
  parameter int N_PC   = 2,
  parameter int N_PP   = 4,
  parameter int N_PS   = 4,
  parameter int N_MSC  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_MPC-1:0]  mpc_int_i,
  input logic [N_MPCX-1:0] mpcx_int_i,
  input logic [N_PC-1:0]   ppc_core_int_i,
  input logic [N_MSC-1:0]  msc_int_i,
  input logic              reg_we,
  input logic [2:0]        reg_addr,
  input logic [31:0]       reg_wdata,
  input logic [31:0]       mpc_word_w,
  input logic [31:0]       ppc_word_w,
  input logic [31:0]       msc_word_w,
  input logic [31:0]       msc_en_w,
  input logic [31:0]       ppc_en_w,
  input logic [N_PC-1:0]   ppc_core_clr_o,
  input logic [N_PP-1:0]   ppc_pexp_clr_o,
  input logic [N_PS-1:0]   ppc_sexp_clr_o,
  input logic [N_MSC-1:0]  msc_clr_o,
  input logic [N_MSC-1:0]  msc_ns_o,
  input logic              msc_irq_o
);
  logic wr_pclr, wr_mclr, wr_pen, wr_mns;
  assign wr_pclr = reg_we && (reg_addr == 3'd2);
  assign wr_mclr = reg_we && (reg_addr == 3'd5);
  assign wr_pen  = reg_we && (reg_addr == 3'd3);
  assign wr_mns  = reg_we && (reg_addr == 3'd7);

  assert_mpc_track_R1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (mpc_word_w[N_MPC-1:0] == $past(mpc_int_i)) &&
             (mpc_word_w[16 +: N_MPCX] == $past(mpcx_int_i)));

  assert_ppc_track_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ppc_word_w[N_PC-1:0] == $past(ppc_core_int_i));

  assert_ppc_en_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_pen |=> $stable(ppc_en_w));

  assert_ppc_clr_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_pclr |=> (ppc_core_clr_o == '0) && (ppc_pexp_clr_o == '0) && (ppc_sexp_clr_o == '0));

  assert_ppc_clr_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pclr |=> (ppc_core_clr_o == $past(ppc_word_w[N_PC-1:0])) &&
                (ppc_pexp_clr_o == $past(ppc_word_w[4 +: N_PP])) &&
                (ppc_sexp_clr_o == $past(ppc_word_w[20 +: N_PS])));

  assert_msc_track_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> msc_word_w[16 +: N_MSC] == $past(msc_int_i));

  assert_msc_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    msc_irq_o == ((msc_word_w & msc_en_w) != 32'd0));

  assert_msc_clr_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_mclr |=> msc_clr_o == '0);

  assert_msc_clr_value_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mclr |=> msc_clr_o == $past(reg_wdata[16 +: N_MSC]));

  assert_msc_ns_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_mns |=> $stable(msc_ns_o));
endmodule

bind sec_irq_agg sia_checker #(
  .N_MPC(N_MPC), .N_MPCX(N_MPCX), .N_PC(N_PC),
  .N_PP(N_PP), .N_PS(N_PS), .N_MSC(N_MSC)
) chk_i (
  .clk(clk), .rst_n(rst_n),
  .mpc_int_i(mpc_int_i), .mpcx_int_i(mpcx_int_i),
  .ppc_core_int_i(ppc_core_int_i), .msc_int_i(msc_int_i),
  .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .mpc_word_w(mpc_word_w), .ppc_word_w(ppc_word_w), .msc_word_w(msc_word_w),
  .msc_en_w(msc_en_w), .ppc_en_w(ppc_en_w),
  .ppc_core_clr_o(ppc_core_clr_o), .ppc_pexp_clr_o(ppc_pexp_clr_o),
  .ppc_sexp_clr_o(ppc_sexp_clr_o), .msc_clr_o(msc_clr_o),
  .msc_ns_o(msc_ns_o), .msc_irq_o(msc_irq_o)
);

// File: tb/sec_irq_agg_tb.sv
`timescale 1ns/1ps
module sec_irq_agg_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  mpc_in = '0, mpcx_in = '0, pexp_in = '0, sexp_in = '0, msc_in = '0;
  logic [1:0]  core_in = '0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  core_en, core_clr;
  logic [3:0]  pexp_en, sexp_en, pexp_clr, sexp_clr, msc_clr, msc_ns;
  logic        msc_irq;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  sec_irq_agg dut_i (
    .clk(clk), .rst_n(rst_n),
    .mpc_int_i(mpc_in), .mpcx_int_i(mpcx_in),
    .ppc_core_int_i(core_in), .ppc_pexp_int_i(pexp_in), .ppc_sexp_int_i(sexp_in),
    .msc_int_i(msc_in),
    .reg_we(we), .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata),
    .ppc_core_en_o(core_en), .ppc_pexp_en_o(pexp_en), .ppc_sexp_en_o(sexp_en),
    .ppc_core_clr_o(core_clr), .ppc_pexp_clr_o(pexp_clr), .ppc_sexp_clr_o(sexp_clr),
    .msc_clr_o(msc_clr), .msc_ns_o(msc_ns), .msc_irq_o(msc_irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
    #1;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    we = 1'b0; addr = a;
    #1;
    d = rdata;
  endtask

  function automatic logic [31:0] exp_ppc(logic [1:0] c, logic [3:0] p, logic [3:0] s);
    return 32'(c) + 32'(p) * 32'd16 + 32'(s) * 32'h0010_0000;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10: reset state
    #1;
    check("R10 outputs", {core_en, pexp_en, sexp_en, core_clr, pexp_clr, sexp_clr,
                          msc_clr, msc_ns, 3'b0, msc_irq}, 32'd0);
    rd(3'd3, r); check("R10 ppc enable", r, 0);
    rd(3'd6, r); check("R10 msc enable", r, 0);
    rd(3'd7, r); check("R10 msc ns", r, 0);

    // R1: every memory controller pattern
    for (int v = 0; v < 256; v++) begin
      mpc_in = v[3:0]; mpcx_in = v[7:4];
      rd(3'd0, r);
      check("R1 mpc status", r, 32'(v[3:0]) + 32'(v[7:4]) * 32'h1_0000);
    end

    // R2: every peripheral controller pattern
    for (int v = 0; v < 1024; v++) begin
      core_in = v[1:0]; pexp_in = v[5:2]; sexp_in = v[9:6];
      rd(3'd1, r);
      check("R2 ppc status", r, exp_ppc(v[1:0], v[5:2], v[9:6]));
    end

    // R9: status words ignore writes
    mpc_in = 4'h5; mpcx_in = 4'hA; core_in = 2'b01; pexp_in = 4'h3; sexp_in = 4'hC; msc_in = 4'h6;
    wr(3'd0, 32'hFFFF_FFFF); wr(3'd1, 32'h0); wr(3'd4, 32'hFFFF_FFFF);
    rd(3'd0, r); check("R9 mpc unchanged", r, 32'h000A_0005);
    rd(3'd1, r); check("R9 ppc unchanged", r, exp_ppc(2'b01, 4'h3, 4'hC));
    rd(3'd4, r); check("R9 msc unchanged", r, 32'h0006_0000);

    // R3: enable word mask and fan-out
    wr(3'd3, 32'hFFFF_FFFF);
    rd(3'd3, r); check("R3 mask", r, 32'h00F0_00F3);
    check("R3 outputs all", {core_en, pexp_en, sexp_en}, 32'h3FF);
    wr(3'd3, 32'h0FA0_0F52);
    rd(3'd3, r); check("R3 partial", r, 32'h00A0_0052);
    check("R3 core en", core_en, 2'b10);
    check("R3 pexp en", pexp_en, 4'b0101);
    check("R3 sexp en", sexp_en, 4'b1010);
    wr(3'd2, 32'h0); wr(3'd7, 32'h0);
    check("R3 hold after other writes", {core_en, pexp_en, sexp_en}, {22'd0, 2'b10, 4'b0101, 4'b1010});

    // R4: clear pulses carry status bits, not data
    for (int v = 0; v < 1024; v += 67) begin
      core_in = v[1:0]; pexp_in = v[5:2]; sexp_in = v[9:6];
      @(negedge clk);
      wr(3'd2, v[0] ? 32'hFFFF_FFFF : 32'h0);
      check("R4 clear pulse", {22'd0, core_clr, pexp_clr, sexp_clr},
            {22'd0, v[1:0], v[5:2], v[9:6]});
      @(negedge clk); #1;
      check("R4 clear one cycle", {core_clr, pexp_clr, sexp_clr}, 0);
    end
    rd(3'd2, r); check("R4 read zero", r, 0);

    // R5/R6: master status and combined interrupt, all pairs
    for (int e = 0; e < 16; e++) begin
      wr(3'd6, 32'hFFF0_FFFF & ~(32'hF << 16) | (32'(e) << 16));
      rd(3'd6, r); check("R6 enable mask", r, 32'(e) << 16);
      for (int s = 0; s < 16; s++) begin
        msc_in = s[3:0];
        @(negedge clk); #1;
        check("R6 combined irq", {31'd0, msc_irq}, {31'd0, (s & e) != 0});
        rd(3'd4, r); check("R5 msc status", r, 32'(s) << 16);
      end
    end

    // R7: master clear pulses from written data
    for (int k = 0; k < 16; k++) begin
      wr(3'd5, (32'(k) << 16) | 32'hFF00_FFFF);
      check("R7 clear pulse", {28'd0, msc_clr}, 32'(k));
      @(negedge clk); #1;
      check("R7 clear one cycle", {28'd0, msc_clr}, 0);
    end
    rd(3'd5, r); check("R7 read zero", r, 0);

    // R8: master non-secure word
    wr(3'd7, 32'hFFF9_FFFF);
    rd(3'd7, r); check("R8 ns mask", r, 32'h0009_0000);
    check("R8 ns outputs", {28'd0, msc_ns}, 32'h9);
    wr(3'd5, 32'h0006_0000);
    check("R8 ns hold", {28'd0, msc_ns}, 32'h9);

    finish_run();
  end
endmodule